// File: doc/BRIEF.md
# Periodic Counter/Timer Interrupt Source

This block is a 16-bit down-counter that raises a periodic interrupt for system timekeeping. It runs on a crystal-derived clock. An internal prescaler turns that clock into one count tick every `PRESCALE` clocks; the default of 2 gives a 1.8432 MHz tick from a 3.6864 MHz crystal. The block is generic and does not require those frequencies.

Software first disables the interrupt with the mask input. It then writes the 16-bit preload as two byte registers, the upper byte and the lower byte. Choosing timer mode and then reading the start offset launches the count. The preload for a wanted rate is the tick frequency divided by that rate. For 100 Hz at 1.8432 MHz this is 18432, so the upper byte is 0x48 and the lower byte is 0x00.

In timer mode the counter reloads at every terminal count, which gives a steady stream of interrupt events. In counter mode it does not reload; it wraps and keeps counting down. Each event sets a sticky pending flag. The flag reaches the output only through the mask input, and a clear strobe acknowledges it.

Top module: `ctr_timer_irq`

## Requirements
- R1: After reset the counter is idle, both preload bytes are 0x00, the pending flag is clear and `irq` is low.
- R2: A write strobe at offset 0x6 loads `wdata` into the upper preload byte, and one at offset 0x7 loads the lower byte. The preload is {upper, lower}, and writes at any other offset have no effect on it.
- R3: The counter does not run until `rd_stb` is seen with `addr` equal to 0xE. A read at any other offset, or a write at 0xE, leaves it idle.
- R4: A tick occurs every `PRESCALE` clocks after the start read. The start read loads the preload, and the pending flag is set P ticks later. With the default prescale of 2, `irq` is high after the clock edge that comes 2P cycles after the edge that sampled the start read.
- R5: In timer mode (`timer_mode`=1) each terminal count reloads the preload, so the pending flag is set again every P ticks.
- R6: A preload of 0 is treated as 65536 ticks.
- R7: In counter mode (`timer_mode`=0) a terminal count sets the pending flag but does not reload. The count wraps, and the next event comes 65536 ticks later.
- R8: `irq` is the pending flag gated by `irq_mask`. The flag is held while the mask is low and appears at `irq` as soon as the mask is raised.
- R9: `clr_stb` clears the pending flag without stopping the counter. If a terminal count lands on the same edge, the set wins.
- R10: A preload written while the counter runs takes effect at the next reload. A new start read restarts the count from the preload at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | Register write strobe |
| rd_stb | input | 1 | Register read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data byte |
| timer_mode | input | 1 | 1 = timer (periodic reload), 0 = counter |
| irq_mask | input | 1 | Interrupt enable bit |
| clr_stb | input | 1 | Pending-flag clear strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench predicts the exact cycle of every interrupt rise and compares it with what it sees. A prescaler that restarted out of phase, or a terminal count that was off by one, would move every rise by one tick. A preload of zero must give 65536 ticks; a design that treated it as zero ticks would fire almost at once. A 256-plus preload catches a design that swaps or drops a byte. A preload rewritten mid-period must not shorten the current period. Counter mode must stay silent after its first event, and a masked event must still appear once the mask is raised.

// File: rtl/ctr_timer_irq.sv
module ctr_timer_irq #(
  parameter int PRESCALE = 2,
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [AW-1:0] ADDR_HI = 4'h6,
  parameter logic [AW-1:0] ADDR_LO = 4'h7,
  parameter logic [AW-1:0] ADDR_START = 4'hE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          timer_mode,
  input  logic          irq_mask,
  input  logic          clr_stb,
  output logic          irq
);
  localparam int CW = 2 * DW;
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [DW-1:0] pl_hi, pl_lo;
  logic [PW-1:0] pre;
  logic [CW-1:0] cnt;
  logic          run, pend;

  wire [CW-1:0] preload = {pl_hi, pl_lo};
  wire          start   = rd_stb && (addr == ADDR_START);
  wire          tick    = run && (pre == PW'(PRESCALE - 1));
  wire          term    = tick && (cnt == CW'(1));

  assign irq = pend & irq_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl_hi <= '0;
      pl_lo <= '0;
    end else if (wr_stb) begin
      if (addr == ADDR_HI) pl_hi <= wdata;
      if (addr == ADDR_LO) pl_lo <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      pre <= '0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      pre <= '0;
      cnt <= preload;
    end else if (run) begin
      pre <= tick ? '0 : pre + PW'(1);
      if (tick) cnt <= (term && timer_mode) ? preload : cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (term)    pend <= 1'b1;
    else if (clr_stb) pend <= 1'b0;
  end
endmodule

// File: rtl/ctr_timer_irq_chk.sv
module ctr_timer_irq_chk #(
  parameter int CW = 16,
  parameter int AW = 4,
  parameter logic [AW-1:0] ADDR_START = 4'hE
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_stb,
  input logic [AW-1:0] addr,
  input logic          clr_stb,
  input logic          timer_mode,
  input logic          run,
  input logic          tick,
  input logic          pend,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] preload
);
  wire st  = rd_stb && (addr == ADDR_START);
  wire fin = tick && (cnt == CW'(1));

  a_r3_idle_until_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !st) |=> (!run && $stable(cnt)));

  a_r4_terminal_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> pend);

  a_r5_reload_on_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && timer_mode && !st) |=> (cnt == $past(preload)));

  a_r8_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr_stb) |=> pend);

  a_r9_clear_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !fin) |=> !pend);

  a_r9_clear_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    (run && clr_stb) |=> run);
endmodule

bind ctr_timer_irq ctr_timer_irq_chk #(.CW(CW), .AW(AW), .ADDR_START(ADDR_START)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .addr(addr), .clr_stb(clr_stb),
  .timer_mode(timer_mode), .run(run), .tick(tick), .pend(pend), .cnt(cnt),
  .preload(preload)
);

// File: tb/ctr_timer_irq_tb_top.sv
`timescale 1ns/1ps
module ctr_timer_irq_tb_top;
  localparam int PS = 2;
  localparam logic [3:0] A_HI = 4'h6, A_LO = 4'h7, A_GO = 4'hE;

  logic clk = 0, rst_n = 0, wr_stb = 0, rd_stb = 0, timer_mode = 1, irq_mask = 1;
  logic clr_drv = 0, clr_mon = 0, irq, irq_q = 0, sb_on = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  wire clr_stb = clr_drv | clr_mon;

  int cyc = 0, checks = 0, errors = 0;
  int exp_q[$];
  string cur_req = "R1";

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ctr_timer_irq #(.PRESCALE(PS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr),
    .wdata(wdata), .timer_mode(timer_mode), .irq_mask(irq_mask),
    .clr_stb(clr_stb), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard at each irq rise and acknowledges it
  always @(negedge clk) begin
    irq_q   <= irq;
    clr_mon <= 1'b0;
    if (sb_on && irq && !irq_q) begin
      int e;
      clr_mon <= 1'b1;
      if (exp_q.size() == 0) chk(0, {cur_req, " unexpected irq"}, cyc, -1);
      else begin
        e = exp_q.pop_front();
        chk(cyc == e, {cur_req, " irq cycle"}, cyc, e);
      end
    end
  end

  task automatic reset_dut();
    sb_on = 0; rst_n = 0; wr_stb = 0; rd_stb = 0; clr_drv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    sb_on = 1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_stb = 1; addr = a; wdata = d;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); rd_stb = 1; addr = a;
    @(negedge clk); rd_stb = 0;
  endtask

  task automatic go(output int t0);
    @(negedge clk); rd_stb = 1; addr = A_GO; t0 = cyc + 1;
    @(negedge clk); rd_stb = 0;
  endtask

  task automatic drain(input int lim, input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < lim) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(exp_q.size() == 0, {req, " missing irq"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1;
    // R1 reset state
    reset_dut();
    chk(irq == 0, "R1 irq after reset", irq, 0);

    // R3 no run before start; R2 foreign write ignored
    cur_req = "R3";
    wr(A_HI, 8'h00); wr(A_LO, 8'h04); wr(4'h5, 8'h01);
    rd(4'h6); wr(A_GO, 8'hFF);
    repeat (40) @(negedge clk);
    chk(irq == 0, "R3 idle without start read", irq, 0);

    // R4 R5 periodic timer, P=4 ticks; R9 clear keeps counting
    cur_req = "R5";
    go(t0);
    exp_q.push_back(t0 + 4*PS); exp_q.push_back(t0 + 8*PS); exp_q.push_back(t0 + 12*PS);
    drain(100, "R5");

    // R2 both bytes: {0x01,0x02} = 258 ticks
    reset_dut(); cur_req = "R2";
    wr(A_HI, 8'h01); wr(A_LO, 8'h02);
    go(t0);
    exp_q.push_back(t0 + 258*PS);
    drain(600, "R2");

    // R10 restart and mid-period preload change
    reset_dut(); cur_req = "R10";
    wr(A_HI, 8'h00); wr(A_LO, 8'h04);
    go(t0);
    repeat (3) @(negedge clk);
    go(t1);
    wr(A_LO, 8'h02);
    exp_q.push_back(t1 + 4*PS); exp_q.push_back(t1 + 6*PS); exp_q.push_back(t1 + 8*PS);
    drain(100, "R10");

    // R7 counter mode: one event then silence
    reset_dut(); cur_req = "R7"; timer_mode = 0;
    wr(A_HI, 8'h00); wr(A_LO, 8'h03);
    go(t0);
    exp_q.push_back(t0 + 3*PS);
    drain(50, "R7");
    repeat (60) @(negedge clk);
    chk(irq == 0, "R7 no reload in counter mode", irq, 0);

    // R8 masked pending held, shown when mask raised
    reset_dut(); cur_req = "R8"; irq_mask = 0;
    wr(A_HI, 8'h00); wr(A_LO, 8'h03);
    go(t0);
    repeat (20) @(negedge clk);
    chk(irq == 0, "R8 masked irq low", irq, 0);
    @(posedge clk); #1; exp_q.push_back(cyc); irq_mask = 1;
    drain(10, "R8");
    @(negedge clk);
    chk(irq == 0, "R9 clear drops irq", irq, 0);
    timer_mode = 1;

    // R4 100 Hz preload {0x48,0x00}
    reset_dut(); cur_req = "R4";
    wr(A_HI, 8'h48); wr(A_LO, 8'h00);
    go(t0);
    exp_q.push_back(t0 + 18432*PS);
    drain(37000, "R4");

    // R6 preload 0 = 65536 ticks
    reset_dut(); cur_req = "R6";
    wr(A_HI, 8'h00); wr(A_LO, 8'h00);
    go(t0);
    exp_q.push_back(t0 + 65536*PS);
    drain(131200, "R6");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule